// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

The block is a watchdog counter that fires a level interrupt, and optionally a fixed-length system reset pulse, when its count reaches a programmed limit. Software cannot change the watchdog configuration by accident. Every write to a guarded register must come right after a two-word unlock handshake, and one guarded write uses that unlock up.

The register bus is a simple single-cycle write strobe with an address and write data. Read data is combinational from the address and never needs an unlock. An external `tick` input paces the counter. The clock gating and reset distribution around the block belong to the surrounding system.

Address map, 3-bit address:
- 0: first key.
- 1: second key.
- 2: limit.
- 3: arm control.
- 4: event status.
- 5: counter clear.
- 6: counter value, read-only.
- 7: reads zero.

Addresses 2 to 5 are guarded. Address 4 reads back as {access error in bit 1, event in bit 0}.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, wdt_rst and wdt_irq are low, the counter reads 0, the limit reads all ones, arm control reads 0, status reads 0 and the unlock state is locked.
- R2: Writing 0xBABA to address 0 and then 0xEB10 to address 1 allows exactly one following write to a guarded address (2 to 5) to take effect. A second guarded write without a new handshake is ignored.
- R3: Any other value written to address 0 or 1, or a write to address 1 that does not directly follow a correct first key, returns the unlock state to locked.
- R4: A guarded write made while locked is ignored and sets the access-error flag (status bit 1). The flag stays set until reset and is not cleared by status writes.
- R5: The counter increases by one on each clock with tick high while arm bit 0 is set, and holds otherwise. Its value reads at address 6 without any unlock.
- R6: An accepted write to address 5 sets the counter to zero, and this wins over a tick in the same cycle.
- R7: With arm bit 0 set, the tick that takes the counter to the limit sets status bit 0 at that clock edge. wdt_irq follows status bit 0. Without arm bit 1, wdt_rst stays low.
- R8: If arm bit 1 is also set, wdt_rst goes high after that same edge and stays high for exactly 16 clock cycles.
- R9: An accepted write to address 4 with data bit 0 equal to 0 clears the event status and drops wdt_irq.
- R10: Writes to addresses 6 and 7 change no register and do not consume or reset the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| wdt_irq | output | 1 | Event status level |
| wdt_rst | output | 1 | System reset pulse |

## Verification
The hardest state to reach from the ports is a reset pulse whose start and length can be checked to the cycle. To get there, the stimulus has to pass three separately unlocked writes, for the limit, the clear and the arm control, and then hold tick steady. The bench sets a short limit of 0xF, holds tick high, and checks wdt_rst on every cycle before, during and after the 16-cycle window. Random phases interleave tick bursts with corrupted key handshakes and good ones, and track the counter, the limit and the error flag in a bench model.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_HALF   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_e;

  localparam logic [2:0] AD_KEY1  = 3'd0;
  localparam logic [2:0] AD_KEY2  = 3'd1;
  localparam logic [2:0] AD_LIMIT = 3'd2;
  localparam logic [2:0] AD_ARM   = 3'd3;
  localparam logic [2:0] AD_STAT  = 3'd4;
  localparam logic [2:0] AD_CLR   = 3'd5;
  localparam logic [2:0] AD_CNT   = 3'd6;

  localparam int ARM_RUN_BIT = 0;
  localparam int ARM_RST_BIT = 1;
endpackage

// File: rtl/kwd_unlock.sv
module kwd_unlock
  import kwd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'hBABA,
  parameter logic [DATA_W-1:0] KEY_B = 16'hEB10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key1_wr,
  input  logic              key2_wr,
  input  logic              guard_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              is_open,
  output logic              deny
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key1_wr) begin
      st_d = (wdata == KEY_A) ? UL_HALF : UL_LOCKED;
    end else if (key2_wr) begin
      st_d = (st_q == UL_HALF && wdata == KEY_B) ? UL_OPEN : UL_LOCKED;
    end else if (guard_wr) begin
      st_d = UL_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_LOCKED;
    else        st_q <= st_d;
  end

  assign is_open = (st_q == UL_OPEN);
  assign deny    = guard_wr && (st_q != UL_OPEN);

  // R2: one guarded write uses up the unlock
  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    guard_wr |=> (st_q == UL_LOCKED));

  // R2: the open state is only reached through a correct second key
  p_open_via_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key2_wr && !(st_q == UL_HALF && wdata == KEY_B)) |=> (st_q != UL_OPEN));

  // R3: a wrong first key locks
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key1_wr && wdata != KEY_A) |=> (st_q == UL_LOCKED));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             step;

  assign step    = run && tick;
  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit   = step && !clr && (cnt_inc == limit);
  assign count = cnt_q;

  // R5: hold when not stepping
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(run && tick)) |=> $stable(count));

  // R5: advance by one on a step
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run && tick) |=> (count == $past(count) + 1'b1));

  // R6: clear wins
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int PW = $clog2(LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(LEN);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (left_q != '0)  left_d = left_q - {{(PW-1){1'b0}}, 1'b1};
    else if (trig)     left_d = LEN_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign active = (left_q != '0);

  // R8: a pulse always starts from its full length
  p_start_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (left_q == LEN_V));

  // R8: a running pulse only counts down
  p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'hBABA,
  parameter logic [DATA_W-1:0] KEY_B = 16'hEB10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  localparam int ARM_W = 2;

  logic             key1_wr, key2_wr, guard_wr, is_open, deny, accept;
  logic [CNT_W-1:0] limit_q, limit_d, count;
  logic [ARM_W-1:0] arm_q, arm_d;
  logic             evt_q, evt_d, err_q, err_d;
  logic             hit, clr;

  assign key1_wr  = bus_wr && (bus_addr == AD_KEY1);
  assign key2_wr  = bus_wr && (bus_addr == AD_KEY2);
  assign guard_wr = bus_wr && (bus_addr == AD_LIMIT || bus_addr == AD_ARM ||
                               bus_addr == AD_STAT  || bus_addr == AD_CLR);
  assign accept   = guard_wr && is_open;
  assign clr      = accept && (bus_addr == AD_CLR);

  kwd_unlock #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk(clk), .rst_n(rst_n), .key1_wr(key1_wr), .key2_wr(key2_wr),
    .guard_wr(guard_wr), .wdata(bus_wdata), .is_open(is_open), .deny(deny)
  );

  kwd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(arm_q[ARM_RUN_BIT]), .tick(tick),
    .clr(clr), .limit(limit_q), .count(count), .hit(hit)
  );

  kwd_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(hit && arm_q[ARM_RST_BIT]), .active(wdt_rst)
  );

  always_comb begin
    limit_d = limit_q;
    arm_d   = arm_q;
    evt_d   = evt_q;
    err_d   = err_q | deny;
    if (accept && bus_addr == AD_LIMIT) limit_d = bus_wdata[CNT_W-1:0];
    if (accept && bus_addr == AD_ARM)   arm_d   = bus_wdata[ARM_W-1:0];
    if (accept && bus_addr == AD_STAT && !bus_wdata[0]) evt_d = 1'b0;
    if (hit) evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '1;
      arm_q   <= '0;
      evt_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      limit_q <= limit_d;
      arm_q   <= arm_d;
      evt_q   <= evt_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AD_LIMIT: bus_rdata = DATA_W'(limit_q);
      AD_ARM:   bus_rdata = DATA_W'(arm_q);
      AD_STAT:  bus_rdata = DATA_W'({err_q, evt_q});
      AD_CNT:   bus_rdata = DATA_W'(count);
      default:  bus_rdata = '0;
    endcase
  end

  assign wdt_irq = evt_q;

  // R4: the access-error flag is sticky
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R4: a denied write leaves the limit untouched
  p_deny_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> $stable(limit_q) && $stable(arm_q));

  // R8: no reset pulse starts unless reset generation was armed
  p_rst_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(arm_q[ARM_RST_BIT]));

  // R7: the event only rises on a match
  p_evt_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(hit));
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        wdt_irq, wdt_rst;

  int total = 0;
  int bad = 0;

  logic [15:0] m_cnt, m_limit;
  logic        m_err;

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(3'd0, 16'hBABA);
    wr(3'd1, 16'hEB10);
  endtask

  function automatic logic [15:0] expect_stat(input logic err, input logic evt);
    return {14'd0, err, evt};
  endfunction

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rst", {31'd0, wdt_rst}, 0);
    chk("R1 irq", {31'd0, wdt_irq}, 0);
    rd(3'd6, v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 limit", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 arm", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);

    // R2 / R5: run the counter, ticks while stopped are ignored
    tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
    rd(3'd6, v); chk("R5 stopped", v, 0);
    unlock(); wr(3'd3, 16'h0001);
    rd(3'd3, v); chk("R2 arm accepted", v, 1);
    wr(3'd3, 16'h0003);
    rd(3'd3, v); chk("R2 second write ignored", v, 1);
    m_err = 1'b1;
    rd(3'd4, v); chk("R4 err after locked write", v, expect_stat(m_err, 1'b0));
    m_cnt = 0; m_limit = 16'hFFFF;

    // random phase
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        n = 1 + ($urandom % 20);
        for (int k = 0; k < n; k++) begin
          @(negedge clk);
          tick = $urandom % 2;
          if (tick) m_cnt++;
        end
        @(negedge clk); tick = 1'b0;
        rd(3'd6, v); chk("R5 count after burst", v, m_cnt);
      end else if (op == 1) begin
        case ($urandom % 3)
          0: wr(3'd0, 16'hBABB);
          1: wr(3'd1, 16'hEB10);
          default: begin wr(3'd0, 16'hBABA); wr(3'd1, 16'hEB11); end
        endcase
        wr(3'd2, 16'h8000 | 16'($urandom % 16'h7000));
        m_err = 1'b1;
        rd(3'd2, v); chk("R3 limit unchanged", v, m_limit);
        rd(3'd4, v); chk("R4 err set", v, expect_stat(m_err, 1'b0));
      end else if (op == 2) begin
        m_limit = 16'h8000 | 16'($urandom % 16'h7000);
        unlock(); wr(3'd2, m_limit);
        rd(3'd2, v); chk("R2 limit written", v, m_limit);
        wr(3'd2, 16'h9999);
        m_err = 1'b1;
        rd(3'd2, v); chk("R2 relock", v, m_limit);
      end else begin
        unlock(); wr(3'd5, 16'h0000);
        m_cnt = 0;
        rd(3'd6, v); chk("R6 clear", v, 0);
      end
    end

    // R6 clear wins over a tick
    tick = 1'b1;
    unlock(); wr(3'd5, 16'h0000);
    tick = 1'b0;
    rd(3'd6, v); chk("R6 clear beats tick", v, 0);

    // R10 writes to read-only addresses keep the unlock
    unlock(); wr(3'd6, 16'h1234); wr(3'd7, 16'h5678); wr(3'd2, 16'h00AA);
    rd(3'd2, v); chk("R10 unlock kept", v, 16'h00AA);
    rd(3'd6, v); chk("R10 count untouched", v, 0);

    // R7 match without reset generation
    unlock(); wr(3'd2, 16'h000F);
    unlock(); wr(3'd5, 16'h0);
    unlock(); wr(3'd3, 16'h0001);
    tick = 1'b1;
    repeat (14) @(negedge clk);
    chk("R7 no irq before match", {31'd0, wdt_irq}, 0);
    @(negedge clk);
    tick = 1'b0;
    chk("R7 irq at match", {31'd0, wdt_irq}, 1);
    n = 0;
    repeat (20) begin @(negedge clk); if (wdt_rst) n++; end
    chk("R7 no reset pulse", n, 0);

    // R9 clear event
    unlock(); wr(3'd4, 16'h0000);
    chk("R9 irq cleared", {31'd0, wdt_irq}, 0);
    rd(3'd4, v); chk("R4 err survives clear", v, expect_stat(m_err, 1'b0));

    // R8 armed reset with short limit
    unlock(); wr(3'd5, 16'h0);
    unlock(); wr(3'd3, 16'h0003);
    tick = 1'b1;
    repeat (14) @(negedge clk);
    chk("R8 no rst before match", {31'd0, wdt_rst}, 0);
    @(negedge clk);
    chk("R8 rst at match", {31'd0, wdt_rst}, 1);
    chk("R8 irq at match", {31'd0, wdt_irq}, 1);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!wdt_rst) break;
      n++;
    end
    tick = 1'b0;
    chk("R8 pulse length", n, 16);
    n = 0;
    repeat (10) begin @(negedge clk); if (wdt_rst) n++; end
    chk("R8 pulse ends", n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule